// File: doc/BRIEF.md
# Conditional Relative Jump Resolver

This block settles the outcome of a program-counter-relative jump. Each cycle that `in_valid` is high it takes the current program counter, which already points past the jump word, together with a 3-bit condition selector, a 10-bit signed word displacement and the four status flags (negative, zero, carry, overflow). It then decides whether the jump is taken and produces the address of the next instruction.

When the selected condition holds, the next address is the program counter plus twice the sign-extended displacement. When the condition fails, the next address is the incoming program counter, so execution simply continues in sequence. The flags are inputs only; the block never writes them back. Both results are registered and appear one clock after the request.

The unit sits between the decode stage, which supplies the selector and displacement, and the fetch stage, which consumes `next_pc`. Fetch, decode of other instruction formats and flag generation are outside this block.

Top module: `reljump_unit`

## Requirements
- R1: While `rst` is high at a rising edge, `out_valid`, `taken` and `next_pc` are all cleared to 0 after that edge.
- R2: A request presented with `in_valid`=1 at a rising edge produces its result, with `out_valid`=1, right after that edge. `out_valid` is 0 after any edge where `in_valid` was 0.
- R3: Selector 0 (not-equal) is taken when Z=0, and selector 1 (equal) is taken when Z=1.
- R4: Selector 2 (unsigned lower) is taken when C=0, and selector 3 (unsigned higher-or-same) is taken when C=1.
- R5: Selector 4 (negative) is taken when N=1 and is not taken when N=0.
- R6: Selector 5 (signed greater-or-equal) is taken when N XOR V = 0, and selector 6 (signed less) is taken when N XOR V = 1.
- R7: Selector 7 (always) is taken for every combination of N, Z, C and V.
- R8: A taken jump yields `next_pc` = `pc_in` + 2 × sign-extended `word_ofs`, with bit 0 forced to 0. The displacement covers −512 to +511 words.
- R9: A jump that is not taken yields `next_pc` equal to `pc_in`.
- R10: After an edge where `in_valid` was 0, `taken` is 0 and `next_pc` keeps its previous value.
- R11: The address sum wraps modulo 2^16 in both directions.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request strobe |
| pc_in | input | 16 | Program counter, already pointing past the jump word |
| cond_sel | input | 3 | Condition selector, encoded as in R3–R7 |
| word_ofs | input | 10 | Signed displacement, counted in words |
| flag_n | input | 1 | Negative flag |
| flag_z | input | 1 | Zero flag |
| flag_c | input | 1 | Carry flag |
| flag_v | input | 1 | Overflow flag |
| out_valid | output | 1 | Result strobe, one cycle after the request |
| taken | output | 1 | High when the registered jump was taken |
| next_pc | output | 16 | Registered address of the next instruction |

## Verification
The bench sweeps every selector across flag combinations chosen so that each condition both passes and fails. A swapped selector code or a condition built from N alone rather than N XOR V would then report a wrong `taken`. It applies the extreme displacements −512 and +511 and addresses near the top and bottom of the address space. A design that zero-extends the displacement, forgets the doubling or truncates the carry wrongly would land on the wrong target there. Idle cycles between requests check that a stale `taken` or a moving `next_pc` cannot leak out when no request was made.

// File: rtl/reljump_pkg.sv
package reljump_pkg;

    localparam int COND_W   = 3;
    localparam int NUM_COND = 1 << COND_W;

    typedef enum logic [COND_W-1:0] {
        CND_NE     = 3'd0,
        CND_EQ     = 3'd1,
        CND_LO     = 3'd2,
        CND_HS     = 3'd3,
        CND_NEG    = 3'd4,
        CND_GE     = 3'd5,
        CND_LT     = 3'd6,
        CND_ALWAYS = 3'd7
    } cond_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } flags_t;

    // Evaluate one condition against the flag set.
    function automatic logic cond_test(input cond_e sel, input flags_t fl);
        logic sgn_lt;
        sgn_lt = fl.n ^ fl.v;
        case (sel)
            CND_NE:     return !fl.z;
            CND_EQ:     return fl.z;
            CND_LO:     return !fl.c;
            CND_HS:     return fl.c;
            CND_NEG:    return fl.n;
            CND_GE:     return !sgn_lt;
            CND_LT:     return sgn_lt;
            default:    return 1'b1;
        endcase
    endfunction

endpackage

// File: rtl/rj_cond_eval.sv
module rj_cond_eval
    import reljump_pkg::*;
(
    input  cond_e  sel,
    input  flags_t fl,
    output logic   hit
);

    logic [NUM_COND-1:0] hit_vec;

    // One evaluator per selector code; the selector then picks a lane.
    generate
        for (genvar g = 0; g < NUM_COND; g++) begin : g_cond
            assign hit_vec[g] = cond_test(cond_e'(COND_W'(g)), fl);
        end
    endgenerate

    assign hit = hit_vec[sel];

endmodule

// File: rtl/rj_target_calc.sv
module rj_target_calc #(
    parameter int PC_W  = 16,
    parameter int OFS_W = 10
) (
    input  logic [PC_W-1:0]  pc,
    input  logic [OFS_W-1:0] ofs,
    output logic [PC_W-1:0]  tgt
);

    localparam int EXT_W = PC_W - OFS_W - 1;
    localparam logic [PC_W-1:0] EVEN_MASK = {{(PC_W-1){1'b1}}, 1'b0};

    logic [PC_W-1:0] disp;
    logic [PC_W-1:0] sum;

    // Sign-extend and double the word displacement in one concatenation.
    assign disp = {{EXT_W{ofs[OFS_W-1]}}, ofs, 1'b0};
    assign sum  = pc + disp;
    assign tgt  = sum & EVEN_MASK;

endmodule

// File: rtl/reljump_unit.sv
module reljump_unit
    import reljump_pkg::*;
#(
    parameter int PC_W  = 16,
    parameter int OFS_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [PC_W-1:0]   pc_in,
    input  logic [COND_W-1:0] cond_sel,
    input  logic [OFS_W-1:0]  word_ofs,
    input  logic              flag_n,
    input  logic              flag_z,
    input  logic              flag_c,
    input  logic              flag_v,
    output logic              out_valid,
    output logic              taken,
    output logic [PC_W-1:0]   next_pc
);

    flags_t          fl;
    cond_e           sel;
    logic            hit;
    logic [PC_W-1:0] tgt;
    logic [PC_W-1:0] pc_nxt;

    assign fl  = '{n: flag_n, z: flag_z, c: flag_c, v: flag_v};
    assign sel = cond_e'(cond_sel);

    rj_cond_eval u_cond (
        .sel (sel),
        .fl  (fl),
        .hit (hit)
    );

    rj_target_calc #(
        .PC_W  (PC_W),
        .OFS_W (OFS_W)
    ) u_tgt (
        .pc  (pc_in),
        .ofs (word_ofs),
        .tgt (tgt)
    );

    assign pc_nxt = hit ? tgt : pc_in;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            taken     <= 1'b0;
            next_pc   <= '0;
        end else if (in_valid) begin
            out_valid <= 1'b1;
            taken     <= hit;
            next_pc   <= pc_nxt;
        end else begin
            out_valid <= 1'b0;
            taken     <= 1'b0;
        end
    end

    AST_RESULT_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);                                          // R2
    AST_IDLE_NO_RESULT: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);                                        // R2
    AST_IDLE_NOT_TAKEN: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> !taken);                                           // R10
    AST_IDLE_PC_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(next_pc));                                  // R10
    AST_ALWAYS_TAKES: assert property (@(posedge clk) disable iff (rst)
        (in_valid && cond_sel == 3'd7) |=> taken);                        // R7
    AST_FALLTHROUGH_PC: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !hit) |=> (next_pc == $past(pc_in)));                // R9
    AST_TARGET_EVEN: assert property (@(posedge clk) disable iff (rst)
        taken |-> !next_pc[0]);                                           // R8

endmodule

// File: tb/sim_reljump_unit.sv
`timescale 1ns/1ps
module sim_reljump_unit;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [15:0] pc_in;
    logic [2:0]  cond_sel;
    logic [9:0]  word_ofs;
    logic        flag_n, flag_z, flag_c, flag_v;
    logic        out_valid, taken;
    logic [15:0] next_pc;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    reljump_unit u0 (
        .clk (clk), .rst (rst), .in_valid (in_valid),
        .pc_in (pc_in), .cond_sel (cond_sel), .word_ofs (word_ofs),
        .flag_n (flag_n), .flag_z (flag_z), .flag_c (flag_c), .flag_v (flag_v),
        .out_valid (out_valid), .taken (taken), .next_pc (next_pc)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Expected decision straight from the selector table in R3..R7.
    function automatic bit model_take(input int code, input bit n, z, c, v);
        case (code)
            0: return z == 0;
            1: return z == 1;
            2: return c == 0;
            3: return c == 1;
            4: return n == 1;
            5: return (n != v) == 0;
            6: return (n != v) == 1;
            default: return 1;
        endcase
    endfunction

    // Expected target per R8/R11, using integer arithmetic.
    function automatic logic [15:0] model_tgt(input logic [15:0] pc, input logic [9:0] ofs);
        int d;
        int s;
        d = int'($signed(ofs)) * 2;
        s = (int'(pc) + d + 65536) % 65536;
        return 16'(s) & 16'hFFFE;
    endfunction

    // Apply one request at a falling edge, check its registered result one cycle later.
    task automatic request(input string req, input logic [15:0] pc, input int code,
                           input logic [9:0] ofs, input bit n, z, c, v);
        bit          tk;
        logic [15:0] ex;
        in_valid = 1'b1; pc_in = pc; cond_sel = 3'(code); word_ofs = ofs;
        flag_n = n; flag_z = z; flag_c = c; flag_v = v;
        tk = model_take(code, n, z, c, v);
        ex = tk ? model_tgt(pc, ofs) : pc;
        @(negedge clk);
        in_valid = 1'b0;
        chk({req, " out_valid"}, 32'(out_valid), 32'd1);
        chk({req, " taken"},     32'(taken),     32'(tk));
        chk({req, " next_pc"},   32'(next_pc),   32'(ex));
    endtask

    task automatic t_reset;
        rst = 1'b1; in_valid = 1'b1; pc_in = 16'h1234; cond_sel = 3'd7;
        word_ofs = 10'd5; flag_n = 0; flag_z = 0; flag_c = 0; flag_v = 0;
        repeat (3) @(negedge clk);
        chk("R1 out_valid", 32'(out_valid), 32'd0);
        chk("R1 taken",     32'(taken),     32'd0);
        chk("R1 next_pc",   32'(next_pc),   32'd0);
        rst = 1'b0; in_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_zero_conds;
        request("R3 ne z0", 16'h0200, 0, 10'd4, 0, 0, 0, 0);
        request("R3 ne z1", 16'h0200, 0, 10'd4, 0, 1, 0, 0);
        request("R3 eq z1", 16'h0300, 1, 10'h3FE, 1, 1, 1, 1);
        request("R3 eq z0", 16'h0300, 1, 10'h3FE, 1, 0, 1, 1);
    endtask

    task automatic t_carry_conds;
        request("R4 lo c0", 16'h0400, 2, 10'd16, 1, 1, 0, 1);
        request("R4 lo c1", 16'h0400, 2, 10'd16, 0, 0, 1, 0);
        request("R4 hs c1", 16'h0500, 3, 10'd7, 0, 1, 1, 0);
        request("R4 hs c0", 16'h0500, 3, 10'd7, 1, 0, 0, 1);
    endtask

    task automatic t_neg;
        request("R5 neg n1", 16'h0600, 4, 10'd9, 1, 0, 0, 0);
        request("R5 neg n0", 16'h0600, 4, 10'd9, 0, 1, 1, 1);
    endtask

    task automatic t_signed;
        for (int k = 0; k < 4; k++) begin
            bit n = k[1];
            bit v = k[0];
            request("R6 ge", 16'h0700, 5, 10'd3, n, 0, 1, v);
            request("R6 lt", 16'h0720, 6, 10'h3FD, n, 1, 0, v);
        end
    endtask

    task automatic t_always;
        for (int f = 0; f < 16; f++)
            request("R7 always", 16'h0800, 7, 10'd33, f[3], f[2], f[1], f[0]);
    endtask

    task automatic t_offsets;
        request("R8 max fwd",  16'h4000, 7, 10'h1FF, 0, 0, 0, 0);
        request("R8 max back", 16'h4000, 7, 10'h200, 0, 0, 0, 0);
        request("R8 zero ofs", 16'h4002, 7, 10'h000, 0, 0, 0, 0);
        request("R8 odd pc",   16'h4003, 7, 10'd1,   0, 0, 0, 0);
        request("R9 fall odd", 16'h4003, 1, 10'd1,   0, 0, 0, 0);
    endtask

    task automatic t_wrap;
        request("R11 wrap up",   16'hFFF0, 7, 10'd20,  0, 0, 0, 0);
        request("R11 wrap down", 16'h0004, 7, 10'h200, 0, 0, 0, 0);
    endtask

    task automatic t_idle;
        logic [15:0] held;
        request("R10 prime", 16'h1000, 7, 10'd8, 0, 0, 0, 0);
        held = next_pc;
        pc_in = 16'hAAAA; cond_sel = 3'd7; word_ofs = 10'd100;
        repeat (2) begin
            @(negedge clk);
            chk("R10 idle out_valid", 32'(out_valid), 32'd0);
            chk("R10 idle taken",     32'(taken),     32'd0);
            chk("R10 idle next_pc",   32'(next_pc),   32'(held));
        end
    endtask

    task automatic t_back_to_back;
        in_valid = 1'b1; pc_in = 16'h2000; cond_sel = 3'd7; word_ofs = 10'd2;
        flag_n = 0; flag_z = 0; flag_c = 0; flag_v = 0;
        @(negedge clk);
        chk("R2 b2b first", 32'(next_pc), 32'h2004);
        pc_in = 16'h3000; cond_sel = 3'd1;
        @(negedge clk);
        chk("R2 b2b second valid", 32'(out_valid), 32'd1);
        chk("R2 b2b second pc",    32'(next_pc),   32'h3000);
        in_valid = 1'b0;
        @(negedge clk);
        chk("R2 idle after", 32'(out_valid), 32'd0);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_zero_conds();
        t_carry_conds();
        t_neg();
        t_signed();
        t_always();
        t_offsets();
        t_wrap();
        t_idle();
        t_back_to_back();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #200000;
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule